// File: doc/BRIEF.md
# Stipple and Block-Copy Raster Engine

This block accelerates pixel writes into an 8-bit-per-pixel framebuffer whose lines are 1024 bytes apart. Software drives it through two write-only command windows, one for stipple and one for blit. Each operation takes two bus writes. The first write goes to a word with address bit 2 clear and latches a data word, whose low byte is the colour. The second write goes to a word with address bit 2 set and starts the operation. That trigger carries the destination pixel in its bus address, at address bits 3 and up.

A stipple trigger turns its 32 data bits into a run of up to 32 colour writes. A blit trigger names a source pixel and a run length in its data word. It either fills the run with the latched colour, or copies the run pixel by pixel from the source, in ascending order. The engine reaches the framebuffer through a single-port byte-wide request/grant interface. It moves at most one pixel per cycle. While an operation is in progress it holds busy high and stalls further triggers through cmd_ready.

Top module: `rop_engine`

## Requirements
- R1: An accepted word write with cmd_addr[2] = 0 stores cmd_wdata as the pending colour. Only the low 8 bits are used later. It starts no memory activity, and it is accepted even while busy.
- R2: An accepted word write with cmd_addr[2] = 1 starts an operation at destination pixel cmd_addr[22:3]. busy rises in the following cycle. cmd_blit = 0 selects stipple and cmd_blit = 1 selects blit.
- R3: Stipple scans the data word from bit 31 down to bit 0. A set bit 31-k writes the colour to pixel destination+k, in ascending k. A clear bit leaves its pixel unwritten. A zero mask writes nothing and still completes.
- R4: For a blit, the run length is cmd_wdata[28:24] plus one, giving 1 to 32 pixels. Bits 31:29 are ignored.
- R5: For a blit, when cmd_wdata[23:0] = 0xFFFFFF, every pixel of the run is filled with the latched colour.
- R6: For any other source, a blit copies pixel source+k to destination+k for k ascending. Each pixel is read before it is written, so an overlapping forward copy repeats the first source byte. The source pixel is cmd_wdata[19:0].
- R7: While busy, a trigger write sees cmd_ready = 0 and is held until the operation ends. The colour used by the running operation is the one captured when it started.
- R8: done pulses high for exactly one cycle when an operation completes, in the same cycle busy falls. Each trigger gives exactly one done pulse.
- R9: The following are ignored and change no state: writes whose cmd_size is not 2 (word), writes whose cmd_addr[1:0] is not 0, and reads. Reads return cmd_rdata = 0.
- R10: After reset, busy, done and mem_req are low, cmd_ready is high and the pending colour is 0.
- R11: A memory request holds mem_addr, mem_we and mem_wdata stable until mem_gnt. Read data arrives with mem_rvalid one cycle after the grant. Pixel addresses wrap modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Bus access request |
| cmd_ready | output | 1 | Access accepted this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_blit | input | 1 | Window select: 0 stipple, 1 blit |
| cmd_addr | input | 23 | Byte address within the window |
| cmd_size | input | 2 | Access size, 2 = 32-bit word |
| cmd_wdata | input | 32 | Write data |
| cmd_rdata | output | 32 | Read data, always zero |
| mem_req | output | 1 | Framebuffer access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Pixel address |
| mem_wdata | output | 8 | Pixel write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the inputs. The memory returns exactly one mem_rvalid, one cycle after each granted read and never otherwise. mem_gnt is free to stall for any number of cycles. The command side holds its access until cmd_ready is seen.

The bench's framebuffer model keeps to these rules. It grants at random, so stalls fall in every state, and it answers every granted read in the next cycle. The command tasks keep cmd_valid high and unchanged until the access is accepted, and they issue triggers while the engine is busy on purpose, so that stalls are exercised.

// File: rtl/rop_pkg.sv
package rop_pkg;
   localparam int WORD_W   = 32;
   localparam int SRC_W    = 24;
   localparam int LEN_LSB  = 24;
   localparam int LEN_W    = 5;
   localparam logic [1:0] SIZE_WORD = 2'd2;

   typedef enum logic [2:0] {
      ST_IDLE, ST_STIP, ST_FILL, ST_CRD, ST_CWAIT, ST_CWR
   } seq_state_t;

   typedef enum logic [1:0] {
      OP_STIP, OP_FILL, OP_COPY
   } op_kind_t;
endpackage

// File: rtl/rop_cmd_decode.sv
module rop_cmd_decode
   import rop_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int PIX_W  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic                  cmd_write,
   input  logic                  cmd_blit,
   input  logic [ADDR_W+2:0]     cmd_addr,
   input  logic [1:0]            cmd_size,
   input  logic [WORD_W-1:0]     cmd_wdata,
   input  logic                  seq_busy,
   output logic                  cmd_ready,
   output logic                  start,
   output op_kind_t              op_kind,
   output logic [ADDR_W-1:0]     dst,
   output logic [ADDR_W-1:0]     src,
   output logic [LEN_W-1:0]      len_m1,
   output logic [WORD_W-1:0]     mask,
   output logic [PIX_W-1:0]      color
);
   logic             word_wr;
   logic             trig_sel;
   logic             fill_sel;
   logic [PIX_W-1:0] latch_q;

   assign word_wr  = cmd_valid && cmd_write && (cmd_size == SIZE_WORD) && (cmd_addr[1:0] == 2'b00);
   assign trig_sel = cmd_addr[2];
   assign cmd_ready = !(word_wr && trig_sel && seq_busy);
   assign start     = word_wr && trig_sel && !seq_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
      end else if (word_wr && !trig_sel) begin
         latch_q <= cmd_wdata[PIX_W-1:0];
      end
   end

   assign fill_sel = (cmd_wdata[SRC_W-1:0] == {SRC_W{1'b1}});
   assign dst      = cmd_addr[3 +: ADDR_W];
   assign src      = cmd_wdata[ADDR_W-1:0];
   assign len_m1   = cmd_blit ? cmd_wdata[LEN_LSB +: LEN_W] : {LEN_W{1'b1}};
   assign op_kind  = !cmd_blit ? OP_STIP : (fill_sel ? OP_FILL : OP_COPY);
   assign mask     = cmd_wdata;
   assign color    = latch_q;
endmodule

// File: rtl/rop_sequencer.sv
module rop_sequencer
   import rop_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int PIX_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  op_kind_t           op_kind,
   input  logic [ADDR_W-1:0]  dst,
   input  logic [ADDR_W-1:0]  src,
   input  logic [LEN_W-1:0]   len_m1,
   input  logic [WORD_W-1:0]  mask,
   input  logic [PIX_W-1:0]   color,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [PIX_W-1:0]   mem_wdata,
   input  logic               mem_gnt,
   input  logic               mem_rvalid,
   input  logic [PIX_W-1:0]   mem_rdata,
   output logic               busy,
   output logic               done
);
   seq_state_t        state_q;
   logic [ADDR_W-1:0] dst_q, src_q;
   logic [WORD_W-1:0] mask_q;
   logic [PIX_W-1:0]  color_q, rbuf_q;
   logic [LEN_W-1:0]  cnt_q, len_q;
   logic              done_q;
   logic              last;

   assign last = (cnt_q == len_q);
   assign busy = (state_q != ST_IDLE);
   assign done = done_q;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = dst_q + ADDR_W'(cnt_q);
      mem_wdata = color_q;
      case (state_q)
         ST_STIP: begin mem_req = mask_q[WORD_W-1]; mem_we = 1'b1; end
         ST_FILL: begin mem_req = 1'b1; mem_we = 1'b1; end
         ST_CRD:  begin mem_req = 1'b1; mem_addr = src_q + ADDR_W'(cnt_q); end
         ST_CWR:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = rbuf_q; end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         dst_q   <= '0;
         src_q   <= '0;
         mask_q  <= '0;
         color_q <= '0;
         rbuf_q  <= '0;
         cnt_q   <= '0;
         len_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (start) begin
               dst_q   <= dst;
               src_q   <= src;
               mask_q  <= mask;
               color_q <= color;
               len_q   <= len_m1;
               cnt_q   <= '0;
               case (op_kind)
                  OP_STIP: state_q <= ST_STIP;
                  OP_FILL: state_q <= ST_FILL;
                  default: state_q <= ST_CRD;
               endcase
            end
            ST_STIP: if (mem_gnt || !mask_q[WORD_W-1]) begin
               mask_q <= mask_q << 1;
               cnt_q  <= cnt_q + 1'b1;
               if (last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end
            end
            ST_FILL: if (mem_gnt) begin
               if (last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_CRD: if (mem_gnt) state_q <= ST_CWAIT;
            ST_CWAIT: if (mem_rvalid) begin
               rbuf_q  <= mem_rdata;
               state_q <= ST_CWR;
            end
            ST_CWR: if (mem_gnt) begin
               if (last) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  cnt_q   <= cnt_q + 1'b1;
                  state_q <= ST_CRD;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rop_engine.sv
module rop_engine
   import rop_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int PIX_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic               cmd_write,
   input  logic               cmd_blit,
   input  logic [ADDR_W+2:0]  cmd_addr,
   input  logic [1:0]         cmd_size,
   input  logic [31:0]        cmd_wdata,
   output logic [31:0]        cmd_rdata,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [PIX_W-1:0]   mem_wdata,
   input  logic               mem_gnt,
   input  logic               mem_rvalid,
   input  logic [PIX_W-1:0]   mem_rdata,
   output logic               busy,
   output logic               done
);
   generate
      if (ADDR_W < 4 || ADDR_W > SRC_W) begin : g_bad_addr_w
         $error("rop_engine: ADDR_W must lie in 4..24");
      end
      if (PIX_W < 1 || PIX_W > WORD_W) begin : g_bad_pix_w
         $error("rop_engine: PIX_W must lie in 1..32");
      end
   endgenerate

   logic              start;
   op_kind_t          op_kind;
   logic [ADDR_W-1:0] dst, src;
   logic [LEN_W-1:0]  len_m1;
   logic [WORD_W-1:0] mask;
   logic [PIX_W-1:0]  color;

   assign cmd_rdata = '0;

   rop_cmd_decode #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_blit(cmd_blit),
      .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_wdata(cmd_wdata),
      .seq_busy(busy), .cmd_ready(cmd_ready), .start(start),
      .op_kind(op_kind), .dst(dst), .src(src), .len_m1(len_m1),
      .mask(mask), .color(color)
   );

   rop_sequencer #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
      .dst(dst), .src(src), .len_m1(len_m1), .mask(mask), .color(color),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .busy(busy), .done(done)
   );
endmodule

// File: rtl/rop_engine_checker.sv
module rop_engine_checker #(
   parameter int ADDR_W = 20,
   parameter int PIX_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              cmd_write,
   input logic              cmd_trig,
   input logic [1:0]        cmd_lsb,
   input logic [1:0]        cmd_size,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [PIX_W-1:0]  mem_wdata,
   input logic              mem_gnt,
   input logic              busy,
   input logic              done
);
   logic word_wr;
   assign word_wr = cmd_valid && cmd_write && cmd_size == 2'd2 && cmd_lsb == 2'b00;

   AST_LATCH_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (word_wr && !cmd_trig) |-> cmd_ready); // R1
   AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (word_wr && cmd_trig && !busy) |=> busy); // R2
   AST_TRIG_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (word_wr && cmd_trig && busy) |-> !cmd_ready); // R7
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R8
   AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R8
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_ODD_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_valid && !word_wr) |=> !busy); // R9
   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy); // R11
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata))); // R11
endmodule

bind rop_engine rop_engine_checker #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_write(cmd_write), .cmd_trig(cmd_addr[2]), .cmd_lsb(cmd_addr[1:0]),
   .cmd_size(cmd_size), .mem_req(mem_req), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
   .busy(busy), .done(done)
);

// File: tb/rop_engine_test.sv
module rop_engine_test;
   localparam int AW = 20;
   localparam int MSK = (1 << AW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_blit = 1'b0;
   logic [22:0] cmd_addr = '0;
   logic [1:0]  cmd_size = 2'd2;
   logic [31:0] cmd_wdata = '0;
   logic        cmd_ready;
   logic [31:0] cmd_rdata;
   logic        mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
   logic [19:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata = '0;
   logic        busy, done;

   always #2.5 clk = ~clk;

   rop_engine uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_write(cmd_write), .cmd_blit(cmd_blit), .cmd_addr(cmd_addr),
      .cmd_size(cmd_size), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .busy(busy), .done(done)
   );

   int tests = 0, fails = 0;
   int exp_done = 0, act_done = 0;
   bit finished = 0;
   logic [7:0] fb   [int];
   logic [7:0] refm [int];
   int   qa[$];
   logic [7:0] qd[$];
   logic [7:0] latch_m = 8'h00;
   bit   rd_pend = 0;
   int   rd_addr = 0;
   bit   rand_gnt = 1;

   function automatic logic [7:0] fb_get(int a);
      return fb.exists(a) ? fb[a] : 8'h00;
   endfunction
   function automatic logic [7:0] ref_get(int a);
      return refm.exists(a) ? refm[a] : 8'h00;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // framebuffer model and per-cycle write comparison
   always @(negedge clk) begin
      mem_rvalid = rd_pend;
      mem_rdata  = fb_get(rd_addr);
      rd_pend    = 0;
      mem_gnt    = rand_gnt ? ($urandom % 3 != 0) : 1'b1;
      #1;
      if (done) begin
         act_done++;
      end
      if (mem_req && mem_gnt) begin
         if (mem_we) begin
            if (qa.size() == 0) begin
               chk(0, "R3", "unexpected pixel write addr", mem_addr, 0);
            end else begin
               int ea;
               logic [7:0] ed;
               ea = qa.pop_front();
               ed = qd.pop_front();
               chk(mem_addr == ea[19:0], "R6", "write address", mem_addr, ea);
               chk(mem_wdata == ed, "R5", "write data", mem_wdata, ed);
            end
            fb[int'(mem_addr)] = mem_wdata;
         end else begin
            rd_pend = 1;
            rd_addr = int'(mem_addr);
         end
      end
   end

   task automatic model_op(input bit blit, input int dst, input logic [31:0] w);
      if (!blit) begin
         for (int k = 0; k < 32; k++) begin
            if (w[31-k]) begin
               int a;
               a = (dst + k) & MSK;
               refm[a] = latch_m;
               qa.push_back(a);
               qd.push_back(latch_m);
            end
         end
      end else begin
         int len, src;
         len = int'(w[28:24]) + 1;
         src = int'(w[23:0]);
         for (int k = 0; k < len; k++) begin
            int a;
            logic [7:0] d;
            a = (dst + k) & MSK;
            d = (src == 24'hFFFFFF) ? latch_m : ref_get((src + k) & MSK);
            refm[a] = d;
            qa.push_back(a);
            qd.push_back(d);
         end
      end
   endtask

   task automatic bus_op(input bit wr, input bit blit, input int addr,
                         input logic [1:0] sz, input logic [31:0] data,
                         output bit stalled);
      @(negedge clk);
      cmd_valid = 1; cmd_write = wr; cmd_blit = blit;
      cmd_addr = addr[22:0]; cmd_size = sz; cmd_wdata = data;
      #1;
      stalled = !cmd_ready;
      while (!cmd_ready) begin
         @(negedge clk);
         #1;
      end
      if (wr && sz == 2'd2 && addr[1:0] == 2'b00) begin
         if (addr[2]) begin
            model_op(blit, (addr >> 3) & MSK, data);
            exp_done++;
         end else begin
            latch_m = data[7:0];
         end
      end
      if (!wr) chk(cmd_rdata == 32'h0, "R9", "read data", cmd_rdata, 0);
      @(negedge clk);
      cmd_valid = 0; cmd_write = 0;
   endtask

   task automatic set_color(input logic [31:0] c);
      bit s;
      bus_op(1, 0, 0, 2'd2, c, s);
   endtask
   task automatic trig(input bit blit, input int dst, input logic [31:0] w);
      bit s;
      bus_op(1, blit, (dst << 3) | 4, 2'd2, w, s);
   endtask
   task automatic wait_idle(input string req);
      #2;
      while (busy) begin
         @(negedge clk);
         #2;
      end
      chk(qa.size() == 0, req, "pending expected writes", qa.size(), 0);
      chk(act_done == exp_done, "R8", "done pulse count", act_done, exp_done);
   endtask
   task automatic preload(input int a, input logic [7:0] d);
      fb[a] = d;
      refm[a] = d;
   endtask

   initial begin
      bit s;
      repeat (3) @(negedge clk);
      #1;
      chk(busy == 0, "R10", "busy after reset", busy, 0);
      chk(mem_req == 0, "R10", "mem_req after reset", mem_req, 0);
      chk(done == 0, "R10", "done after reset", done, 0);
      rst_n = 1;
      @(negedge clk);
      #1;
      chk(cmd_ready == 1, "R10", "ready after reset", cmd_ready, 1);

      // R10: pending colour resets to zero; fill of 2
      preload(10, 8'h77); preload(11, 8'h77);
      trig(1, 10, 32'h01FFFFFF);
      wait_idle("R10");
      chk(fb_get(10) == 8'h00, "R10", "reset colour pixel", fb_get(10), 0);

      // R5/R4: fill length 1 and 32 with junk in 31:29
      set_color(32'hDEAD_BE5A);
      trig(1, 1024, 32'h00FFFFFF);
      wait_idle("R4");
      chk(fb_get(1025) == 8'h00, "R4", "pixel past length-1 run", fb_get(1025), 0);
      trig(1, 2048, 32'hFFFFFFFF);
      wait_idle("R5");
      chk(fb_get(2048 + 31) == 8'h5A, "R5", "last filled pixel", fb_get(2079), 8'h5A);

      // R3: stipple patterns
      set_color(32'h0000_00C3);
      preload(3000 + 1, 8'h11);
      trig(0, 3000, 32'h8000_0001);
      wait_idle("R3");
      chk(fb_get(3001) == 8'h11, "R3", "clear-bit pixel untouched", fb_get(3001), 8'h11);
      trig(0, 4000, 32'hFFFF_FFFF);
      wait_idle("R3");
      trig(0, 5000, 32'h0000_0000);
      wait_idle("R3");
      trig(0, 6000, 32'h5A00_F00F);
      wait_idle("R3");

      // R6: non-overlapping then overlapping forward copy
      for (int i = 0; i < 8; i++) preload(100 + i, 8'(8'h10 + i));
      trig(1, 500, {3'b000, 5'd3, 24'd100});
      wait_idle("R6");
      chk(fb_get(503) == 8'h13, "R6", "copied pixel", fb_get(503), 8'h13);
      trig(1, 101, {3'b000, 5'd4, 24'd100});
      wait_idle("R6");
      chk(fb_get(105) == 8'h10, "R6", "overlap repeats first byte", fb_get(105), 8'h10);

      // R11: address wrap
      set_color(32'h0000_00E1);
      trig(1, 20'hFFFFE, 32'h03FFFFFF);
      wait_idle("R11");
      chk(fb_get(1) == 8'hE1, "R11", "wrapped pixel", fb_get(1), 8'hE1);

      // R9: ignored accesses
      set_color(32'h0000_00A5);
      bus_op(1, 0, 0, 2'd0, 32'h0000_003C, s);
      bus_op(1, 0, 1, 2'd2, 32'h0000_003D, s);
      bus_op(1, 1, (7000 << 3) | 4, 2'd1, 32'h00FFFFFF, s);
      #1;
      chk(busy == 0, "R9", "busy after half-word trigger", busy, 0);
      bus_op(0, 1, (7000 << 3) | 4, 2'd2, 32'h0, s);
      #1;
      chk(busy == 0, "R9", "busy after read", busy, 0);
      trig(1, 7100, 32'h01FFFFFF);
      wait_idle("R9");
      chk(fb_get(7101) == 8'hA5, "R9", "colour after ignored writes", fb_get(7101), 8'hA5);

      // R7/R1: stall triggers, latch while busy
      trig(1, 8000, {3'b000, 5'd31, 24'd100});
      bus_op(1, 0, 0, 2'd2, 32'h0000_0066, s);
      chk(s == 0, "R1", "latch write stalled while busy", s, 0);
      chk(busy == 1, "R7", "copy still busy", busy, 1);
      bus_op(1, 0, (9000 << 3) | 4, 2'd2, 32'hF000_0000, s);
      chk(s == 1, "R7", "trigger not stalled while busy", s, 1);
      wait_idle("R7");
      chk(fb_get(9003) == 8'h66, "R7", "colour latched during busy", fb_get(9003), 8'h66);

      // no stalls at all: back-to-back grants
      rand_gnt = 0;
      trig(1, 600, {3'b111, 5'd7, 24'd100});
      wait_idle("R6");

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL R8 watchdog: actual=hung expected=complete");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule